// File: doc/BRIEF.md
# Timer Control and Count Access Port

This block is the byte-wide host side of a three-channel interval timer. A two-bit address picks either one of the channel count ports (addresses 0 to 2) or the control port (address 3). Control writes either program a channel (access mode, operating mode, BCD flag), capture a channel's running count, or, with a channel-select value of 3, issue a read-back command that can capture the count and/or a status byte for any subset of channels in one write.

The counters themselves sit outside. The port hands each counter a one-cycle load strobe with the assembled 16-bit start value, plus its current mode and BCD flag. It samples each counter's live count, its output level and a "count taken" pulse that tells the port a written value has been moved into the counting element. Count bytes are sequenced low then high for 16-bit transfers, separately for writes and reads, and each channel keeps its own captured count and captured status until software reads them out.

Reads are a one-way stream with no back-pressure: a read strobe is always accepted, and the byte appears on `rd_data` with `rd_valid` high for exactly one cycle, one cycle later. There is no ready signal; the consumer must take the byte in that cycle. A write and a read in the same cycle is resolved in favour of the write.

Top module: `timer_access_port`

## Requirements
- R1: After reset every channel has access mode low-byte-only (code 01), operating mode 0, BCD 0, no captured count or status and a clear null flag; `rd_valid` and all load strobes are low.
- R2: A control write (address 3) with bits 7:6 = channel 0..2 and bits 5:4 nonzero stores bits 5:4 as that channel's access mode, bits 3:1 as its mode and bit 0 as its BCD flag; `cfg_mode`/`cfg_bcd` show the new values the next cycle and other channels are unchanged.
- R3: Mode codes 6 and 7 are stored as 2 and 3.
- R4: Count writes load per access mode: 01 loads the byte, 10 loads the byte shifted left by 8, 11 holds the first byte and loads second<<8 | first on the second write; the load strobe of that channel pulses for one cycle, the cycle after the completing write, with the value on `load_val`.
- R5: A control write with access bits 00 captures the channel's live count; reads then return the captured bytes in the channel's access mode (code 11: low byte, then high byte, then the capture is released) before any live value.
- R6: A capture command for a channel whose captured count (or status) is still unread is ignored for that item; count and status capture are independent.
- R7: A read-back command has bits 7:6 = 11; bits 1, 2, 3 select channels 0, 1, 2; bit 5 = 0 captures the count and bit 4 = 0 captures the status of each selected channel.
- R8: The status byte is bit 7 = counter output, bit 6 = null flag, bits 5:4 = access mode, bits 3:1 = mode, bit 0 = BCD, taken at the command.
- R9: A read returns a captured status first, then a captured count, then live count bytes.
- R10: Uncaptured reads return the live low byte in mode 01, the live high byte in mode 10, and in mode 11 alternate low, high, low, starting with low.
- R11: Programming a channel resets both its write and its read byte order to low byte first.
- R12: The null flag is set when a count is loaded and cleared by the channel's `cnt_taken` pulse; a load in the same cycle as `cnt_taken` leaves it set.
- R13: A read of address 3 returns 0x00 and changes nothing; a read with `wr_en` high in the same cycle is dropped (no `rd_valid`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | 0..2 channel count port, 3 control port |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid with `rd_valid` |
| rd_valid | output | 1 | One-cycle read data qualifier |
| live_cnt | input | 48 | Live counts, channel c at bits 16c+15:16c |
| cnt_out | input | 3 | Counter output level per channel |
| cnt_taken | input | 3 | Pulse: counter has taken the loaded value |
| load_strb | output | 3 | One-cycle load strobe per channel |
| load_val | output | 48 | Load value, channel c at bits 16c+15:16c |
| cfg_mode | output | 9 | Operating mode, channel c at bits 3c+2:3c |
| cfg_bcd | output | 3 | BCD flag per channel |

## Verification
The bench builds the block with its default of three channels, the only count that the read-back select bits can address, so all three channels run at once in different access modes (word, high-only, low-only) and cross-channel isolation of capture and read-back is visible. This brings the status/count/live read priority, ignored re-captures, byte-order resets by reprogramming and the same-cycle null-flag race within reach of one sequence.

// File: rtl/tport_pkg.sv
package tport_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  // access field codes; ACC_NONE doubles as "no captured count"
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_WORD = 2'b11
  } acc_e;

  // codes 6 and 7 alias 2 and 3
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return m[1] ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/tport_decode.sv
module tport_decode
  import tport_pkg::*;
#(
  parameter int NCH = 3,
  localparam int AW = $clog2(NCH + 1)
) (
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:1] cw_hi,
  output logic [NCH-1:0]    prog,
  output logic [NCH-1:0]    cnt_cap,
  output logic [NCH-1:0]    st_cap,
  output logic [NCH-1:0]    cnt_wr
);
  logic ctl_hit, rdbk;
  logic [1:0] sel, accf;

  assign ctl_hit = wr_en && (addr == AW'(NCH));
  assign sel     = cw_hi[7:6];
  assign accf    = cw_hi[5:4];
  assign rdbk    = (sel == 2'b11);

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic direct, viarb;
    assign direct     = ctl_hit && !rdbk && (sel == 2'(c));
    assign viarb      = ctl_hit && rdbk && cw_hi[c+1];
    assign prog[c]    = direct && (accf != ACC_NONE);
    assign cnt_cap[c] = (direct && (accf == ACC_NONE)) || (viarb && !cw_hi[5]);
    assign st_cap[c]  = viarb && !cw_hi[4];
    assign cnt_wr[c]  = wr_en && (addr == AW'(c));
  end
endmodule

// File: rtl/tport_chan.sv
module tport_chan
  import tport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic [5:0]        cw_lo,
  input  logic              cnt_cap,
  input  logic              st_cap,
  input  logic              cnt_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_take,
  input  logic [CNT_W-1:0]  live,
  input  logic              out_lvl,
  input  logic              taken,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              ld_strb,
  output logic [CNT_W-1:0]  ld_val,
  output logic [2:0]        mode_o,
  output logic              bcd_o
);
  acc_e              acc, cap_st;
  logic [2:0]        mode;
  logic              bcd, wr_hi, rd_hi, st_pend, null_f;
  logic [BYTE_W-1:0] lo_hold, st_val;
  logic [CNT_W-1:0]  cap_val;

  assign mode_o = mode;
  assign bcd_o  = bcd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= ACC_LO;       mode <= '0;     bcd <= 1'b0;
      wr_hi <= 1'b0;       rd_hi <= 1'b0;  lo_hold <= '0;
      cap_st <= ACC_NONE;  cap_val <= '0;
      st_pend <= 1'b0;     st_val <= '0;   null_f <= 1'b0;
      ld_strb <= 1'b0;     ld_val <= '0;
    end else begin
      ld_strb <= 1'b0;
      if (taken) null_f <= 1'b0;
      if (prog) begin
        acc   <= acc_e'(cw_lo[5:4]);
        mode  <= fold_mode(cw_lo[3:1]);
        bcd   <= cw_lo[0];
        wr_hi <= 1'b0;
        rd_hi <= 1'b0;
      end
      if (cnt_cap && cap_st == ACC_NONE) begin
        cap_val <= live;
        cap_st  <= acc;
      end
      if (st_cap && !st_pend) begin
        st_pend <= 1'b1;
        st_val  <= {out_lvl, null_f, acc, mode, bcd};
      end
      if (cnt_wr) begin
        unique case (acc)
          ACC_HI: begin
            ld_val <= {wr_byte, {BYTE_W{1'b0}}}; ld_strb <= 1'b1; null_f <= 1'b1;
          end
          ACC_WORD: begin
            if (!wr_hi) begin
              lo_hold <= wr_byte; wr_hi <= 1'b1;
            end else begin
              ld_val <= {wr_byte, lo_hold}; ld_strb <= 1'b1; null_f <= 1'b1;
              wr_hi  <= 1'b0;
            end
          end
          default: begin
            ld_val <= {{BYTE_W{1'b0}}, wr_byte}; ld_strb <= 1'b1; null_f <= 1'b1;
          end
        endcase
      end
      if (rd_take) begin
        if (st_pend)                 st_pend <= 1'b0;
        else if (cap_st != ACC_NONE) cap_st <= (cap_st == ACC_WORD) ? ACC_HI : ACC_NONE;
        else if (acc == ACC_WORD)    rd_hi <= !rd_hi;
      end
    end
  end

  always_comb begin
    if (st_pend)
      rd_byte = st_val;
    else if (cap_st != ACC_NONE)
      rd_byte = (cap_st == ACC_HI) ? cap_val[CNT_W-1:BYTE_W] : cap_val[BYTE_W-1:0];
    else if (acc == ACC_HI || (acc == ACC_WORD && rd_hi))
      rd_byte = live[CNT_W-1:BYTE_W];
    else
      rd_byte = live[BYTE_W-1:0];
  end
endmodule

// File: rtl/timer_access_port.sv
module timer_access_port
  import tport_pkg::*;
#(
  parameter int NCH = 3,
  localparam int AW = $clog2(NCH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [AW-1:0]         addr,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic [BYTE_W-1:0]     rd_data,
  output logic                  rd_valid,
  input  logic [NCH*CNT_W-1:0]  live_cnt,
  input  logic [NCH-1:0]        cnt_out,
  input  logic [NCH-1:0]        cnt_taken,
  output logic [NCH-1:0]        load_strb,
  output logic [NCH*CNT_W-1:0]  load_val,
  output logic [NCH*3-1:0]      cfg_mode,
  output logic [NCH-1:0]        cfg_bcd
);
  logic [NCH-1:0]    prog, cnt_cap, st_cap, cnt_wr;
  logic [BYTE_W-1:0] ch_byte [NCH];
  logic [BYTE_W-1:0] sel_byte;
  logic              rd_fire;

  assign rd_fire = rd_en && !wr_en;

  tport_decode #(.NCH(NCH)) u_dec (
    .wr_en(wr_en), .addr(addr), .cw_hi(wr_data[BYTE_W-1:1]),
    .prog(prog), .cnt_cap(cnt_cap), .st_cap(st_cap), .cnt_wr(cnt_wr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tport_chan u_ch (
      .clk(clk), .rst_n(rst_n),
      .prog(prog[c]), .cw_lo(wr_data[5:0]),
      .cnt_cap(cnt_cap[c]), .st_cap(st_cap[c]),
      .cnt_wr(cnt_wr[c]), .wr_byte(wr_data),
      .rd_take(rd_fire && addr == AW'(c)),
      .live(live_cnt[c*CNT_W +: CNT_W]),
      .out_lvl(cnt_out[c]), .taken(cnt_taken[c]),
      .rd_byte(ch_byte[c]),
      .ld_strb(load_strb[c]), .ld_val(load_val[c*CNT_W +: CNT_W]),
      .mode_o(cfg_mode[c*3 +: 3]), .bcd_o(cfg_bcd[c])
    );
  end

  always_comb begin
    sel_byte = '0;
    for (int c = 0; c < NCH; c++)
      if (addr == AW'(c)) sel_byte = ch_byte[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= sel_byte;
    end
  end
endmodule

// File: rtl/tport_chk.sv
module tport_chk #(
  parameter int NCH = 3,
  localparam int AW = $clog2(NCH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic              rd_valid,
  input logic [NCH-1:0]    load_strb,
  input logic [NCH*3-1:0]  cfg_mode
);
  assert_rd_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> rd_valid);
  assert_rd_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> !rd_valid);
  assert_one_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_strb));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_load_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_strb[c] |-> $past(wr_en && addr == AW'(c)));
    assert_mode_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_mode[c*3+2] && cfg_mode[c*3+1]));
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en && addr == AW'(NCH)) |-> $stable(cfg_mode[c*3 +: 3]));
  end
endmodule

bind timer_access_port tport_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rd_valid(rd_valid), .load_strb(load_strb), .cfg_mode(cfg_mode)
);

// File: tb/sim_timer_access_port.sv
module sim_timer_access_port;
  localparam int NCH = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [15:0] lv [NCH];
  logic [47:0] live_cnt;
  logic [2:0]  cnt_out = 3'b101, cnt_taken = '0;
  logic [2:0]  load_strb;
  logic [47:0] load_val;
  logic [8:0]  cfg_mode;
  logic [2:0]  cfg_bcd;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0]  exp_rd [$];
  string       tag_rd [$];
  logic [31:0] exp_ld [$];
  string       tag_ld [$];

  assign live_cnt = {lv[2], lv[1], lv[0]};
  always #5 clk = ~clk;

  timer_access_port #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .live_cnt(live_cnt), .cnt_out(cnt_out), .cnt_taken(cnt_taken),
    .load_strb(load_strb), .load_val(load_val),
    .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk(0, "R13 unexpected read", rd_data, 0);
        else begin
          automatic logic [7:0] e = exp_rd.pop_front();
          automatic string t = tag_rd.pop_front();
          chk(rd_data == e, t, rd_data, e);
        end
      end
      for (int c = 0; c < NCH; c++) if (load_strb[c]) begin
        automatic logic [31:0] got = {c[15:0], load_val[c*16 +: 16]};
        if (exp_ld.size() == 0) chk(0, "R4 unexpected load", got, 0);
        else begin
          automatic logic [31:0] e = exp_ld.pop_front();
          automatic string t = tag_ld.pop_front();
          chk(got == e, t, got, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_ld(input logic [1:0] a, input logic [7:0] d, input logic [15:0] v, input string t);
    exp_ld.push_back({14'd0, a, v}); tag_ld.push_back(t);
    wr(a, d);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    exp_rd.push_back(e); tag_rd.push_back(t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_taken(input int c);
    @(negedge clk); cnt_taken[c] = 1'b1;
    @(negedge clk); cnt_taken[c] = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    lv[0] = 16'h1234; lv[1] = 16'hABCD; lv[2] = 16'h5A0F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(load_strb == 3'b0, "R1 load_strb", load_strb, 0);
    chk(cfg_mode == 9'b0 && cfg_bcd == 3'b0, "R1 cfg", {cfg_mode, cfg_bcd}, 0);
    wr(3, 8'hEE);                       // R7 status of all three
    rd(0, 8'h90, "R1 R8 status ch0");
    rd(1, 8'h10, "R1 R8 status ch1");
    rd(2, 8'h90, "R1 R8 status ch2");
    rd(1, 8'hCD, "R10 live low byte");

    // R2 R3 programming
    wr(3, 8'h3F);
    chk(cfg_mode == 9'o003 && cfg_bcd == 3'b001, "R3 mode7->3 ch0", {cfg_mode, cfg_bcd}, {9'o003, 3'b001});
    wr(3, 8'h6C);
    chk(cfg_mode == 9'o023 && cfg_bcd == 3'b001, "R3 mode6->2 ch1", {cfg_mode, cfg_bcd}, {9'o023, 3'b001});
    wr(3, 8'h9A);
    chk(cfg_mode == 9'o523 && cfg_bcd == 3'b001, "R2 ch2 mode5", {cfg_mode, cfg_bcd}, {9'o523, 3'b001});

    // R4 loads
    wr_ld(2, 8'h77, 16'h0077, "R4 low-only load");
    wr_ld(1, 8'h42, 16'h4200, "R4 high-only load");
    wr(0, 8'h11);
    wr_ld(0, 8'h22, 16'h2211, "R4 word load");

    // R12 null flag
    wr(3, 8'hE2);
    rd(0, 8'hF7, "R12 R8 null set");
    pulse_taken(0);
    wr(3, 8'hE2);
    rd(0, 8'hB7, "R12 null cleared");
    pulse_taken(2);
    cnt_taken[2] = 1'b1;
    wr_ld(2, 8'h05, 16'h0005, "R4 load during taken");
    cnt_taken[2] = 1'b0;
    wr(3, 8'hE8);
    rd(2, 8'hDA, "R12 set wins over taken");

    // R5 count capture, word mode
    wr(3, 8'h00);
    lv[0] = 16'h5678;
    rd(0, 8'h34, "R5 captured low");
    rd(0, 8'h12, "R5 captured high");
    rd(0, 8'h78, "R10 live after release low");
    rd(0, 8'h56, "R10 alternate high");
    rd(0, 8'h78, "R10 alternate low");

    // R6 repeated captures ignored
    wr(3, 8'h40);
    lv[1] = 16'h1111;
    wr(3, 8'h40);
    rd(1, 8'hAB, "R6 first capture kept");
    rd(1, 8'h11, "R6 released to live");
    wr(3, 8'hE4);
    cnt_out[1] = 1'b1;
    wr(3, 8'hE4);
    rd(1, 8'h64, "R6 first status kept");
    rd(1, 8'h11, "R6 status released");

    // R9 priority and R7 selection
    wr(3, 8'hC8);
    lv[2] = 16'h3344;
    rd(2, 8'hDA, "R9 status first");
    rd(2, 8'h0F, "R9 count second");
    rd(2, 8'h44, "R9 live last");
    wr(3, 8'hD4);
    lv[1] = 16'h2222; lv[0] = 16'hCAFE;
    rd(1, 8'h11, "R7 ch1 count captured");
    rd(0, 8'hCA, "R7 ch0 not captured");

    // R11 byte order reset
    wr(0, 8'h33);
    wr(3, 8'h3F);
    wr(0, 8'h44);
    wr_ld(0, 8'h55, 16'h5544, "R11 write order reset");
    rd(0, 8'hFE, "R11 read low");
    wr(3, 8'h3F);
    rd(0, 8'hFE, "R11 read order reset");

    // R13 address 3 read and write/read collision
    rd(3, 8'h00, "R13 control read");
    rd(2, 8'h44, "R13 no state change");
    exp_ld.push_back({14'd0, 2'd2, 16'h0009}); tag_ld.push_back("R13 write wins");
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 2'd2; wr_data = 8'h09;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk(rd_valid == 1'b0, "R13 read dropped", rd_valid, 0);

    repeat (4) @(negedge clk);
    chk(exp_rd.size() == 0, "R13 reads outstanding", exp_rd.size(), 0);
    chk(exp_ld.size() == 0, "R4 loads outstanding", exp_ld.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule